// File: doc/BRIEF.md
# VID Reference Slew Controller

This block turns a two-bit voltage-identification code into a digital reference word, in millivolts, for a step-down regulator's voltage loop. It never jumps the reference: it walks it by one millivolt per slew tick toward the target the code selects. It does this when the regulator is enabled, starting from zero, and again whenever the code changes later. The slew rate is set by a clock-divider input, so ramp time depends on that setting alone.

While the reference is walking, a transition flag stays high so that downstream power-good logic can be blanked. On any ramp after the first one, the block also asks the power stage for forced-PWM operation, so that the output is driven actively in both directions. That request is held for a fixed window after the ramp ends. A done flag reports that the reference has settled on its target. Dropping enable returns the reference to zero and clears every flag at once.

Top module: `vid_ramp_ctrl`

## Requirements
- R1: The accepted code selects the target: 2'b00 gives 900 mV, 2'b01 gives 775 mV, 2'b10 gives 850 mV and 2'b11 gives 750 mV. Code bit 1 is `vid[1]`.
- R2: After enable rises, the reference starts at 0 and climbs to the target. `fpwm_req` stays low for this whole first ramp.
- R3: The reference moves one millivolt every `tick_div`+1 clock cycles. A ramp of T mV therefore keeps `ramping` high for T×(`tick_div`+1) cycles.
- R4: While enabled, the reference changes by at most 1 mV per cycle. A code change during a ramp turns the ramp toward the new target from the present value.
- R5: On every ramp after the first settle, in either direction, `fpwm_req` is high for the whole ramp.
- R6: After such a ramp ends, `fpwm_req` stays high for exactly HOLD_CYC further cycles and then drops.
- R7: `ramping` is high exactly while the enabled reference differs from the target. `done` is high exactly while enabled and not ramping.
- R8: While `en` is low, `ref_mv` is 0 and `ramping`, `fpwm_req` and `done` are low, in the same cycle that `en` falls.
- R9: The code passes two synchronizer flops and is accepted only once two consecutive synchronized samples agree. A steady change starts a ramp on the fourth clock edge after it, and a code that lasts one cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Regulator enable |
| vid | input | 2 | Asynchronous voltage-identification code |
| tick_div | input | TICK_W | Slew divider: one mV step per tick_div+1 cycles |
| ref_mv | output | REF_W | Present reference in millivolts |
| ramping | output | 1 | Transition in progress (power-good blanking) |
| fpwm_req | output | 1 | Forced-PWM request |
| done | output | 1 | Reference settled on target |

## Verification
The bench measures ramp length under several divider settings. A wrong tick count shows up there as a ramp that is longer or shorter than target×(divider+1). It checks that the first ramp after enable never raises forced-PWM, and that later ramps hold the request for exactly the hold window; an off-by-one hold counter or a missing startup exemption fails those counts. It redirects a ramp halfway and watches every cycle for a jump larger than 1 mV, which would expose a design that reloads the reference. It also injects a one-cycle code glitch and measures acceptance latency, which catches a missing or shortened filter.

// File: rtl/vid_ramp_pkg.sv
package vid_ramp_pkg;

  // R1: code-to-target table
  function automatic int unsigned code_to_mv(input logic [1:0] code);
    case (code)
      2'b00:   return 900;
      2'b01:   return 775;
      2'b10:   return 850;
      default: return 750;
    endcase
  endfunction

  // R4: one millivolt toward the target
  function automatic int unsigned step_toward(input int unsigned cur, input int unsigned tgt);
    if (cur < tgt)      return cur + 1;
    else if (cur > tgt) return cur - 1;
    else                return cur;
  endfunction

endpackage

// File: rtl/vid_code_filter.sv
module vid_code_filter #(
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_acc
);
  logic [CODE_W-1:0] sync1_q, sync2_q, prev_q;

  // R9: two synchronizer flops, then accept on two equal samples
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      prev_q   <= '0;
      code_acc <= '0;
    end else begin
      sync1_q <= code_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      if (sync2_q == prev_q) code_acc <= prev_q;
    end
  end
endmodule

// File: rtl/slew_tick_gen.sv
module slew_tick_gen #(
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] div,
  output logic              tick
);
  logic [TICK_W-1:0] cnt_q;

  assign tick = run && (cnt_q >= div);

  // R3: one tick every div+1 cycles while running
  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (tick)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ref_ramp.sv
module ref_ramp
  import vid_ramp_pkg::*;
#(
  parameter int REF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [REF_W-1:0] target,
  input  logic             tick,
  output logic [REF_W-1:0] ref_q,
  output logic             ramping,
  output logic             last_step
);
  logic [REF_W-1:0] next_ref;

  assign next_ref  = REF_W'(step_toward(int'(ref_q), int'(target)));
  // R7: ramping while the reference differs from the target
  assign ramping   = en && (ref_q != target);
  assign last_step = tick && ramping && (next_ref == target);

  // R2/R4/R8: walk from zero, one step per tick, clear when disabled
  always_ff @(posedge clk) begin
    if (!rst_n || !en)       ref_q <= '0;
    else if (tick && ramping) ref_q <= next_ref;
  end
endmodule

// File: rtl/fpwm_hold.sv
module fpwm_hold #(
  parameter int HOLD_CYC = 64,
  localparam int HOLD_W  = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ramping,
  input  logic last_step,
  output logic fpwm,
  output logic boot
);
  logic [HOLD_W-1:0] hold_q;
  logic              boot_q;

  // R2: first ramp after enable is the startup ramp
  always_ff @(posedge clk) begin
    if (!rst_n || !en)  boot_q <= 1'b1;
    else if (last_step) boot_q <= 1'b0;
  end

  // R6: hold window after a non-startup ramp
  always_ff @(posedge clk) begin
    if (!rst_n || !en)              hold_q <= '0;
    else if (last_step && !boot_q)  hold_q <= HOLD_W'(HOLD_CYC);
    else if (ramping)               hold_q <= '0;
    else if (hold_q != '0)          hold_q <= hold_q - 1'b1;
  end

  assign boot = boot_q;
  // R5: request during later ramps and through the hold window
  assign fpwm = en && ((ramping && !boot_q) || (hold_q != '0));
endmodule

// File: rtl/vid_ramp_ctrl.sv
module vid_ramp_ctrl
  import vid_ramp_pkg::*;
#(
  parameter int REF_W    = 10,
  parameter int TICK_W   = 16,
  parameter int HOLD_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [1:0]        vid,
  input  logic [TICK_W-1:0] tick_div,
  output logic [REF_W-1:0]  ref_mv,
  output logic              ramping,
  output logic              fpwm_req,
  output logic              done
);
  logic [1:0]       code_w;
  logic [REF_W-1:0] target_w;
  logic [REF_W-1:0] ref_w;
  logic             ramp_w;
  logic             tick_w;
  logic             last_step_w;
  logic             fpwm_w;
  logic             boot_w;

  vid_code_filter #(.CODE_W(2)) u_filt (
    .clk(clk), .rst_n(rst_n), .code_in(vid), .code_acc(code_w)
  );

  // R1
  assign target_w = REF_W'(code_to_mv(code_w));

  slew_tick_gen #(.TICK_W(TICK_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ramp_w), .div(tick_div), .tick(tick_w)
  );

  ref_ramp #(.REF_W(REF_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(en), .target(target_w), .tick(tick_w),
    .ref_q(ref_w), .ramping(ramp_w), .last_step(last_step_w)
  );

  fpwm_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .en(en), .ramping(ramp_w),
    .last_step(last_step_w), .fpwm(fpwm_w), .boot(boot_w)
  );

  // R8: outputs forced off in the cycle enable falls
  assign ref_mv   = en ? ref_w : '0;
  assign ramping  = ramp_w;
  assign fpwm_req = fpwm_w;
  assign done     = en && !ramp_w;
endmodule

// File: rtl/vid_ramp_ctrl_chk.sv
module vid_ramp_ctrl_chk #(
  parameter int REF_W    = 10,
  parameter int HOLD_CYC = 64,
  localparam int CNT_W   = $clog2(HOLD_CYC + 2) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [REF_W-1:0] ref_mv,
  input logic             ramping,
  input logic             fpwm_req,
  input logic             done,
  input logic             boot_w
);
  logic [CNT_W-1:0] tail_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                     tail_cnt <= '0;
    else if (fpwm_req && !ramping)  tail_cnt <= tail_cnt + 1'b1;
    else                            tail_cnt <= '0;
  end

  a_r4_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |->
      ((REF_W+1)'(ref_mv) <= (REF_W+1)'($past(ref_mv)) + 1'b1) &&
      ((REF_W+1)'($past(ref_mv)) <= (REF_W+1)'(ref_mv) + 1'b1));

  a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (ref_mv == '0) && !ramping && !fpwm_req && !done);

  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramping && done));

  a_r6_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tail_cnt <= CNT_W'(HOLD_CYC));

  a_r2_no_fpwm_startup: assert property (@(posedge clk) disable iff (!rst_n)
    (ramping && boot_w) |-> !fpwm_req);
endmodule

bind vid_ramp_ctrl vid_ramp_ctrl_chk #(.REF_W(REF_W), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .ref_mv(ref_mv), .ramping(ramping),
  .fpwm_req(fpwm_req), .done(done), .boot_w(boot_w)
);

// File: tb/sim_vid_ramp_ctrl.sv
module sim_vid_ramp_ctrl;
  localparam int CLK_P    = 10;
  localparam int REF_W    = 10;
  localparam int TICK_W   = 16;
  localparam int HOLD_CYC = 64;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [1:0]        vid = 2'b00;
  logic [TICK_W-1:0] tick_div = '0;
  logic [REF_W-1:0]  ref_mv;
  logic              ramping, fpwm_req, done;

  int checks = 0;
  int errors = 0;

  // code, divider, expected mV, expected ramp cycles
  localparam int VEC[4][4] = '{
    '{0, 0, 900,  900},
    '{1, 1, 775, 1550},
    '{2, 0, 850,  850},
    '{3, 2, 750, 2250}
  };

  always #(CLK_P/2) clk = ~clk;

  vid_ramp_ctrl #(.REF_W(REF_W), .TICK_W(TICK_W), .HOLD_CYC(HOLD_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .vid(vid), .tick_div(tick_div),
    .ref_mv(ref_mv), .ramping(ramping), .fpwm_req(fpwm_req), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wait_start(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      if (ramping) seen = 1'b1;
      else cyc(1);
    end
  endtask

  // count ramp cycles, forced-PWM cycles and jumps above 1 mV
  task automatic ramp_len(output int n, output int fp, output int jumps);
    int prev;
    n = 0; fp = 0; jumps = 0;
    prev = int'(ref_mv);
    while (ramping && n < 20000) begin
      n++;
      if (fpwm_req) fp++;
      cyc(1);
      if (int'(ref_mv) > prev + 1 || int'(ref_mv) + 1 < prev) jumps++;
      prev = int'(ref_mv);
    end
  endtask

  task automatic tail_len(output int n);
    n = 0;
    while (fpwm_req && n < 1000) begin
      n++;
      cyc(1);
    end
  endtask

  task automatic start(input logic [1:0] c, input int d);
    int n, fp, j;
    en = 1'b0; vid = c; tick_div = TICK_W'(d);
    cyc(6);
    en = 1'b1;
    #1;
    ramp_len(n, fp, j);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, fp, jmp, tl;
    bit seen;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // reset state (R8)
    chk(ref_mv == 0, "R8 reset ref", int'(ref_mv), 0);
    chk(!ramping && !fpwm_req && !done, "R8 reset flags",
        int'({ramping, fpwm_req, done}), 0);

    // vector table: startup ramps (R1 R2 R3 R7)
    for (int v = 0; v < 4; v++) begin
      en = 1'b0; vid = 2'(VEC[v][0]); tick_div = TICK_W'(VEC[v][1]);
      cyc(6);
      en = 1'b1;
      #1;
      ramp_len(n, fp, jmp);
      chk(n == VEC[v][3], "R3 ramp length", n, VEC[v][3]);
      chk(int'(ref_mv) == VEC[v][2], "R1 target", int'(ref_mv), VEC[v][2]);
      chk(fp == 0, "R2 no fpwm on startup", fp, 0);
      chk(done && !ramping, "R7 done after ramp", int'(done), 1);
    end

    // down ramp 900 -> 850 (R5 R6)
    start(2'b00, 0);
    vid = 2'b10;
    wait_start(seen);
    ramp_len(n, fp, jmp);
    chk(n == 50 && fp == 50, "R5 fpwm on down ramp", fp, 50);
    tail_len(tl);
    chk(tl == HOLD_CYC, "R6 hold length", tl, HOLD_CYC);
    chk(int'(ref_mv) == 850, "R1 down target", int'(ref_mv), 850);

    // up ramp 850 -> 900 at divider 1 (R5 R3)
    tick_div = TICK_W'(1);
    vid = 2'b00;
    wait_start(seen);
    ramp_len(n, fp, jmp);
    chk(fp == 100, "R5 fpwm on up ramp", fp, 100);
    chk(n == 100, "R3 up ramp length", n, 100);
    tail_len(tl);
    chk(tl == HOLD_CYC, "R6 hold after up ramp", tl, HOLD_CYC);

    // one-cycle glitch ignored (R9)
    vid = 2'b01;
    cyc(1);
    vid = 2'b00;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      chk(!ramping && ref_mv == 900, "R9 glitch ignored", int'(ref_mv), 900);
    end

    // acceptance latency (R9): ramp visible after the 4th edge
    vid = 2'b11;
    cyc(3);
    chk(!ramping, "R9 not yet accepted", int'(ramping), 0);
    cyc(1);
    chk(ramping, "R9 accepted on 4th edge", int'(ramping), 1);

    // mid-ramp redirect (R4)
    tick_div = TICK_W'(3);
    while (ref_mv > 850) cyc(1);
    vid = 2'b01;
    ramp_len(n, fp, jmp);
    chk(jmp == 0, "R4 no jump", jmp, 0);
    chk(int'(ref_mv) == 775, "R4 redirect target", int'(ref_mv), 775);

    // enable drop mid-ramp (R8)
    tail_len(tl);
    vid = 2'b00;
    wait_start(seen);
    cyc(20);
    en = 1'b0;
    #1;
    chk(ref_mv == 0, "R8 ref cleared", int'(ref_mv), 0);
    chk(!ramping && !fpwm_req && !done, "R8 flags cleared",
        int'({ramping, fpwm_req, done}), 0);

    // re-enable: startup from zero without fpwm (R2 R3)
    cyc(2);
    en = 1'b1;
    #1;
    chk(ref_mv == 0 && ramping, "R2 restart from zero", int'(ref_mv), 0);
    ramp_len(n, fp, jmp);
    chk(n == 3600, "R3 restart length", n, 3600);
    chk(fp == 0, "R2 restart no fpwm", fp, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule